// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Function Unit

This block is a purely combinational function unit for a register-file datapath. It takes two operands, A and B, and a 4-bit function select. It returns one result word together with carry and overflow flags. Three sections compute in parallel, and an output multiplexer picks one of them:

- **Adder section.** A ripple adder forms A + Y + cin. Y is built per bit from B by a two-bit select.
- **Bitwise section.** Computes AND, OR, XOR, or the complement of A.
- **Single-step shifter.** Acts on B only.

The function select is read as follows:

- **Bits 3 and 2 both set:** the shifter drives the result.
- **Otherwise:** bit 3 is the mode (0 adder, 1 bitwise). Bits 2 and 1 choose Y, and bit 0 is the adder's carry-in.

The enclosing datapath registers the result. This unit holds no state, so its outputs follow its inputs within the same cycle. The operand width is a parameter. The function select is always 4 bits.

Top module: `fu_core`

## Requirements
- R1: fs_i = 0000 gives f_o = A, and fs_i = 0001 gives f_o = A + 1, both modulo 2^WIDTH.
- R2: fs_i = 0010 gives f_o = A + B, and fs_i = 0011 gives f_o = A + B + 1.
- R3: fs_i = 0100 gives f_o = A + ~B, and fs_i = 0101 gives f_o = A − B (that is, A + ~B + 1).
- R4: fs_i = 0110 gives f_o = A − 1 (A plus all ones), and fs_i = 0111 gives f_o = A (A plus all ones plus 1).
- R5: For fs_i[3] = 0, carry_o is bit WIDTH of the full-precision sum A + Y + fs_i[0]. Here Y is 0, B, ~B or all ones for fs_i[2:1] = 00, 01, 10, 11.
- R6: For fs_i[3] = 0, ovf_o is 1 exactly when A and Y have equal sign bits and the sign bit of f_o differs from them (two's-complement overflow).
- R7: For fs_i[3:2] = 10, fs_i[1:0] selects the bitwise result: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, 11 gives NOT A.
- R8: For fs_i[3:2] = 11, fs_i[1:0] selects the shifter result:
  - 00 and 11 pass B unchanged.
  - 01 shifts B right by one and fills the MSB with 0.
  - 10 shifts B left by one and fills the LSB with 0.
- R9: Whenever fs_i[3] = 1, carry_o and ovf_o are both 0.
- R10: For shifter codes (fs_i[3:2] = 11), A has no effect on f_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B, also the shifter input |
| fs_i | input | 4 | Function select |
| f_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Adder carry-out, 0 outside arithmetic codes |
| ovf_o | output | 1 | Signed overflow, 0 outside arithmetic codes |

## Verification
The bound checker watches the unit continuously, whatever the operands, on several relations:

- the flags stay quiet for all non-arithmetic codes;
- addition with its carry is correct;
- subtraction is correct;
- the overflow rule holds for addition;
- XOR is correct;
- the pass-through shifter code returns B.

The remaining encodings (increment, decrement, the complemented-B add, the other bitwise operations and both shift directions, including their zero fill) are exercised only by the bench's vector table and its sweep. The bench also covers the boundary operands that make carry and overflow flip (0x7F+1, 0xFF+1, 0x80−1). The independence of the shifter result from A shows only in the bench, because it compares outputs across separate input sets.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_B    = 2'b01,
    YSEL_NB   = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } logic_op_e;

  typedef enum logic [1:0] {
    SOP_PASS  = 2'b00,
    SOP_SHR   = 2'b01,
    SOP_SHL   = 2'b10,
    SOP_PASS2 = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    SEC_ARITH = 2'b00,
    SEC_LOGIC = 2'b01,
    SEC_SHIFT = 2'b10
  } section_e;

  typedef struct packed {
    section_e  sec;
    ysel_e     ysel;
    logic      cin;
    logic_op_e lop;
    shift_op_e sop;
  } fs_dec_t;

  function automatic fs_dec_t decode_fs(input logic [3:0] fs);
    fs_dec_t d;
    if (fs[3] && fs[2]) d.sec = SEC_SHIFT;
    else if (fs[3])     d.sec = SEC_LOGIC;
    else                d.sec = SEC_ARITH;
    d.ysel = ysel_e'(fs[2:1]);
    d.cin  = fs[0];
    d.lop  = logic_op_e'(fs[1:0]);
    d.sop  = shift_op_e'(fs[1:0]);
    return d;
  endfunction
endpackage

// File: rtl/fu_arith.sv
module fu_arith
  import fu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  ysel_e            ysel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   c;

  // per-bit B-side select logic
  for (genvar i = 0; i < WIDTH; i++) begin : g_ybit
    always_comb begin
      unique case (ysel_i)
        YSEL_ZERO: y[i] = 1'b0;
        YSEL_B:    y[i] = b_i[i];
        YSEL_NB:   y[i] = ~b_i[i];
        default:   y[i] = 1'b1;
      endcase
    end
  end

  // ripple chain kept in one process
  always_comb begin
    c[0] = cin_i;
    for (int k = 0; k < WIDTH; k++) begin
      sum_o[k] = a_i[k] ^ y[k] ^ c[k];
      c[k+1]   = (a_i[k] & y[k]) | (c[k] & (a_i[k] ^ y[k]));
    end
  end

  assign carry_o = c[WIDTH];
  assign ovf_o   = c[WIDTH] ^ c[MSB];
endmodule

// File: rtl/fu_logic.sv
module fu_logic
  import fu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_op_e        op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      LOP_AND: res_o = a_i & b_i;
      LOP_OR:  res_o = a_i | b_i;
      LOP_XOR: res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/fu_shift.sv
module fu_shift
  import fu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  shift_op_e        op_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shr;
  logic [WIDTH-1:0] shl;

  assign shr = {1'b0, b_i[MSB:1]};
  assign shl = {b_i[MSB-1:0], 1'b0};

  always_comb begin
    unique case (op_i)
      SOP_SHR: res_o = shr;
      SOP_SHL: res_o = shl;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/fu_core.sv
module fu_core
  import fu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       fs_i,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_o,
  output logic             ovf_o
);
  fs_dec_t          dec;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] shift_res;
  logic             arith_c;
  logic             arith_v;

  assign dec = decode_fs(fs_i);

  fu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .ysel_i (dec.ysel),
    .cin_i  (dec.cin),
    .sum_o  (arith_res),
    .carry_o(arith_c),
    .ovf_o  (arith_v)
  );

  fu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (dec.lop),
    .res_o(logic_res)
  );

  fu_shift #(.WIDTH(WIDTH)) u_shift (
    .b_i  (b_i),
    .op_i (dec.sop),
    .res_o(shift_res)
  );

  always_comb begin
    f_o     = arith_res;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    unique case (dec.sec)
      SEC_LOGIC: f_o = logic_res;
      SEC_SHIFT: f_o = shift_res;
      default: begin
        f_o     = arith_res;
        carry_o = arith_c;
        ovf_o   = arith_v;
      end
    endcase
  end
endmodule

// File: rtl/fu_core_chk.sv
module fu_core_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       fs_i,
  input logic [WIDTH-1:0] f_i,
  input logic             carry_i,
  input logic             ovf_i
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (fs_i[3]) begin
      AST_FLAGS_QUIET: assert (!carry_i && !ovf_i); // R9
    end
    if (fs_i == 4'b0010) begin
      AST_ADD_CARRY: assert ({carry_i, f_i} == ({1'b0, a_i} + {1'b0, b_i})); // R5
      AST_ADD_OVF: assert (ovf_i == ((a_i[MSB] == b_i[MSB]) && (f_i[MSB] != a_i[MSB]))); // R6
    end
    if (fs_i == 4'b0101) begin
      AST_SUB_RESULT: assert (f_i == WIDTH'(a_i - b_i)); // R3
    end
    if (fs_i == 4'b1010) begin
      AST_XOR_RESULT: assert (f_i == (a_i ^ b_i)); // R7
    end
    if (fs_i == 4'b1100) begin
      AST_SHIFT_PASS: assert (f_i == b_i); // R8
    end
  end
endmodule

bind fu_core fu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .fs_i   (fs_i),
  .f_i    (f_o),
  .carry_i(carry_o),
  .ovf_i  (ovf_o)
);

// File: tb/fu_core_tb_top.sv
module fu_core_tb_top;
  localparam int W    = 8;
  localparam int NVEC = 22;
  localparam int VW   = 4 + 3 * W + 2;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, f;
  logic [3:0]   fs;
  logic         c, v;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  fu_core #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .fs_i(fs), .f_o(f), .carry_o(c), .ovf_o(v)
  );

  // {fs, a, b, expected f, carry, ovf}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {4'b0010, 8'h05, 8'h03, 8'h08, 1'b0, 1'b0}, // R2
    {4'b0010, 8'h07, 8'h1C, 8'h23, 1'b0, 1'b0}, // R2
    {4'b0010, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1}, // R6
    {4'b0010, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0}, // R5
    {4'b0011, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0}, // R2
    {4'b0000, 8'h3C, 8'hAA, 8'h3C, 1'b0, 1'b0}, // R1
    {4'b0001, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0}, // R1
    {4'b0101, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0}, // R3
    {4'b0101, 8'h03, 8'h05, 8'hFE, 1'b0, 1'b0}, // R3
    {4'b0101, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1}, // R6
    {4'b0100, 8'h0F, 8'h0F, 8'hFF, 1'b0, 1'b0}, // R3
    {4'b0110, 8'h00, 8'h55, 8'hFF, 1'b0, 1'b0}, // R4
    {4'b0110, 8'h80, 8'h00, 8'h7F, 1'b1, 1'b1}, // R4
    {4'b0111, 8'h42, 8'h99, 8'h42, 1'b1, 1'b0}, // R4
    {4'b1000, 8'hCC, 8'hAA, 8'h88, 1'b0, 1'b0}, // R7
    {4'b1001, 8'hCC, 8'hAA, 8'hEE, 1'b0, 1'b0}, // R7
    {4'b1010, 8'hCC, 8'hAA, 8'h66, 1'b0, 1'b0}, // R7
    {4'b1011, 8'hCC, 8'hAA, 8'h33, 1'b0, 1'b0}, // R7
    {4'b1100, 8'h12, 8'hA5, 8'hA5, 1'b0, 1'b0}, // R8
    {4'b1101, 8'h12, 8'hA5, 8'h52, 1'b0, 1'b0}, // R8
    {4'b1110, 8'h12, 8'hA5, 8'h4A, 1'b0, 1'b0}, // R8
    {4'b1111, 8'h12, 8'hA5, 8'hA5, 1'b0, 1'b0}  // R8, R9
  };

  task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s fs=%b a=%h b=%h actual={c,v,f}=%h expected=%h", req, fs, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] fs_v, input logic [W-1:0] a_v, input logic [W-1:0] b_v);
    @(negedge clk);
    fs = fs_v; a = a_v; b = b_v;
    #1;
  endtask

  // expected values derived from the requirement text
  function automatic logic [W+1:0] model(input logic [3:0] m_fs, input logic [W-1:0] m_a,
                                         input logic [W-1:0] m_b);
    logic [W-1:0] y, r;
    logic [W:0]   s;
    logic         ov;
    if (!m_fs[3]) begin
      case (m_fs[2:1])
        2'b00:   y = '0;
        2'b01:   y = m_b;
        2'b10:   y = ~m_b;
        default: y = '1;
      endcase
      s  = {1'b0, m_a} + {1'b0, y} + {{W{1'b0}}, m_fs[0]};
      ov = (m_a[W-1] == y[W-1]) && (s[W-1] != m_a[W-1]);
      return {s[W], ov, s[W-1:0]};
    end
    if (!m_fs[2]) begin
      case (m_fs[1:0])
        2'b00:   r = m_a & m_b;
        2'b01:   r = m_a | m_b;
        2'b10:   r = m_a ^ m_b;
        default: r = ~m_a;
      endcase
    end else begin
      case (m_fs[1:0])
        2'b01:   r = m_b >> 1;
        2'b10:   r = m_b << 1;
        default: r = m_b;
      endcase
    end
    return {2'b00, r};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ref_f;
    logic [7:0]   lfsr = 8'h5A;
    logic [7:0]   lfsr2 = 8'hC3;
    fs = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    #1;
    // reset state: zero inputs give zero result and quiet flags (R1)
    check("R1", {c, v, f}, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][VW-1 -: 4], VEC[i][VW-5 -: W], VEC[i][VW-5-W -: W]);
      check(VEC[i][VW-1] ? (VEC[i][VW-2] ? "R8" : "R7") : "R1..R6",
            {c, v, f}, {VEC[i][1], VEC[i][0], VEC[i][VW-5-2*W -: W]});
    end

    // R10: A has no effect on shifter codes
    for (int s = 12; s < 16; s++) begin
      apply(4'(s), 8'h00, 8'h81);
      ref_f = f;
      for (int k = 0; k < 4; k++) begin
        apply(4'(s), 8'(k * 8'h55 + 8'h13), 8'h81);
        check("R10", {c, v, f}, {2'b00, ref_f});
      end
    end

    // R8 zero fill at both ends
    apply(4'b1101, 8'hFF, 8'hFF); check("R8", {c, v, f}, {2'b00, 8'h7F});
    apply(4'b1110, 8'h00, 8'hFF); check("R8", {c, v, f}, {2'b00, 8'hFE});

    // R9 flags quiet even where the adder would carry
    apply(4'b1000, 8'hFF, 8'hFF); check("R9", {c, v, f}, {2'b00, 8'hFF});

    // sweep all codes with pseudo-random operands (R5, R6 and the rest)
    for (int n = 0; n < 320; n++) begin
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      lfsr2 = {lfsr2[6:0], lfsr2[7] ^ lfsr2[5] ^ lfsr2[4] ^ lfsr2[3]};
      apply(4'(n % 16), lfsr, lfsr2);
      check("R5/R6 sweep", {c, v, f}, model(fs, a, b));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule